// File: doc/BRIEF.md
# Segment Translation and Protection Unit

This block turns a logical address, given as a segment number and an offset inside that segment, into a physical address. The segment table sits in memory. Two configuration registers describe it: a table base register holds the word address of entry 0, and a segment-count register holds how many segments are in use. For each request the unit checks the segment number against the count. It then fetches the entry from word address base plus segment number over a memory read port. Next it tests the entry's valid bit, its length limit and its read, write and execute rights. Only when every test passes does it return base plus offset.

A failed test gives a fault code and no address. One fault code exists for each kind of check. A one-entry cache holds the most recently fetched entry, tagged by segment number. Back-to-back accesses to the same segment therefore skip the table read. Any write to either configuration register empties the cache. Each request receives exactly one single-cycle response. The unit accepts no new request until that response has been given.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset, `req_ready` is 1, while `rsp_valid` and `mem_rd_req` are 0. Both configuration registers read as 0, and the cache holds nothing.
- R2: On a cache miss, the unit raises `mem_rd_req` for exactly one cycle, with `mem_rd_addr` equal to the table base register plus the zero-extended segment number.
- R3: A table word packs these fields, from least significant upward: base in bits [15:0], limit (length in bytes, 13 bits) in bits [28:16], execute right in bit 29, write right in bit 30, read right in bit 31, and valid in bit 32.
- R4: A segment number greater than or equal to the segment-count register gives fault code 1 (out of range). No table read takes place, and the response arrives in the cycle after acceptance.
- R5: An entry whose valid bit is 0 gives fault code 2 (invalid).
- R6: An offset greater than or equal to the entry's limit gives fault code 3 (over limit). A limit of 0 therefore rejects every offset.
- R7: The access-type codes are 0 for read, 1 for write and 2 for fetch. An access whose matching right bit is clear gives fault code 4 (denied).
- R8: When several checks fail, the lowest-numbered fault code among 1, 2, 3 and 4 is reported.
- R9: A passing access returns fault code 0 and a physical address equal to base plus offset, taken modulo 2^16.
- R10: Whenever the fault code is non-zero, `rsp_pa` is 0.
- R11: An in-range access to the segment whose entry is cached uses that entry, even if the memory has since changed. It makes no table read and responds in the cycle after acceptance.
- R12: A write to either configuration register invalidates the cache, so the next access to the same segment reads the table again.
- R13: `rsp_valid` lasts one cycle per request, and `req_ready` is 0 from acceptance until that response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_base_we | input | 1 | Write strobe for the table base register |
| cfg_base_wdata | input | 16 | New table base (word address) |
| cfg_len_we | input | 1 | Write strobe for the segment-count register |
| cfg_len_wdata | input | 5 | New segment count |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit idle, able to take a request |
| req_seg | input | 4 | Segment number |
| req_off | input | 12 | Offset in the segment |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 fetch |
| rsp_valid | output | 1 | Response strobe |
| rsp_fault | output | 3 | 0 none, 1 range, 2 invalid, 3 limit, 4 denied |
| rsp_pa | output | 16 | Physical address, 0 on a fault |
| mem_rd_req | output | 1 | Table read request |
| mem_rd_addr | output | 16 | Table word address |
| mem_rd_valid | input | 1 | Table read data present |
| mem_rd_data | input | 33 | Table word |

## Verification
The bench tries a table that mixes full-rights, read-only, write-only, invalid, zero-limit and wrapping-base entries. Access types are chosen so that each right bit is seen both granted and refused. Some entries fail two checks at once, such as an invalid entry with an oversize offset, or a write-only entry read past its limit. These cases separate the fault priority from plain detection. Segment numbers equal to and above the count separate the range test from the table contents. Repeated accesses, carried out after the memory image has been altered and before and after configuration writes, separate cache hits, which show the stale entry, fast latency and no read, from misses.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_RANGE   = 3'd1,
    FLT_INVALID = 3'd2,
    FLT_LIMIT   = 3'd3,
    FLT_DENIED  = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } state_e;

  // Right selected by the access type; an unknown type is never allowed.
  function automatic logic rights_allow(input logic [1:0] acc,
                                        input logic rd, input logic wr,
                                        input logic ex);
    logic ok;
    case (acc)
      ACC_READ:  ok = rd;
      ACC_WRITE: ok = wr;
      ACC_FETCH: ok = ex;
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/seg_xlate_cache.sv
module seg_xlate_cache #(
  parameter int SEG_W = 4,
  parameter int EW    = 33
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inval,
  input  logic             fill,
  input  logic [SEG_W-1:0] fill_seg,
  input  logic [EW-1:0]    fill_entry,
  input  logic [SEG_W-1:0] look_seg,
  output logic             hit,
  output logic [EW-1:0]    hit_entry,
  output logic             vld
);

  logic [SEG_W-1:0] tag_q;
  logic [EW-1:0]    data_q;
  logic             vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      tag_q  <= '0;
      data_q <= '0;
    end else if (inval) begin
      vld_q <= 1'b0;
    end else if (fill) begin
      vld_q  <= 1'b1;
      tag_q  <= fill_seg;
      data_q <= fill_entry;
    end
  end

  assign hit       = vld_q && (tag_q == look_seg);
  assign hit_entry = data_q;
  assign vld       = vld_q;

endmodule

// File: rtl/seg_xlate_check.sv
module seg_xlate_check
  import seg_xlate_pkg::*;
#(
  parameter int OFF_W = 12,
  parameter int PA_W  = 16,
  parameter int LIM_W = 13,
  parameter int EW    = 33
) (
  input  logic             in_range,
  input  logic [EW-1:0]    entry,
  input  logic [OFF_W-1:0] off,
  input  logic [1:0]       acc,
  output logic [2:0]       fault,
  output logic [PA_W-1:0]  pa,
  output logic             ent_ok,
  output logic             lim_ok,
  output logic             perm_ok
);

  localparam int LIM_LO = PA_W;
  localparam int LIM_HI = PA_W + LIM_W - 1;
  localparam int X_BIT  = PA_W + LIM_W;
  localparam int W_BIT  = X_BIT + 1;
  localparam int R_BIT  = X_BIT + 2;
  localparam int V_BIT  = X_BIT + 3;

  function automatic logic [PA_W-1:0] base_plus_off(input logic [PA_W-1:0] b,
                                                    input logic [OFF_W-1:0] o);
    return b + {{(PA_W-OFF_W){1'b0}}, o};
  endfunction

  function automatic logic inside_len(input logic [OFF_W-1:0] o,
                                      input logic [LIM_W-1:0] len);
    return {{(LIM_W-OFF_W){1'b0}}, o} < len;
  endfunction

  logic [PA_W-1:0]  e_base;
  logic [LIM_W-1:0] e_lim;

  assign e_base  = entry[PA_W-1:0];
  assign e_lim   = entry[LIM_HI:LIM_LO];
  assign ent_ok  = entry[V_BIT];
  assign lim_ok  = inside_len(off, e_lim);
  assign perm_ok = rights_allow(acc, entry[R_BIT], entry[W_BIT], entry[X_BIT]);
  assign pa      = base_plus_off(e_base, off);

  always_comb begin
    if (!in_range)     fault = FLT_RANGE;
    else if (!ent_ok)  fault = FLT_INVALID;
    else if (!lim_ok)  fault = FLT_LIMIT;
    else if (!perm_ok) fault = FLT_DENIED;
    else               fault = FLT_NONE;
  end

endmodule

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
  import seg_xlate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic fast,
  input  logic mem_rd_valid,
  input  logic cfg_wr,
  output logic req_ready,
  output logic accept,
  output logic rd_issue,
  output logic ent_from_mem,
  output logic fill_en,
  output logic resp
);

  state_e st_q, st_d;
  logic   fill_ok_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (req_valid) st_d = fast ? ST_RESP : ST_ISSUE;
      ST_ISSUE: st_d = ST_WAIT;
      ST_WAIT:  if (mem_rd_valid) st_d = ST_RESP;
      ST_RESP:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      fill_ok_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (cfg_wr)      fill_ok_q <= 1'b0;
      else if (accept) fill_ok_q <= 1'b1;
    end
  end

  assign req_ready    = (st_q == ST_IDLE);
  assign accept       = req_ready && req_valid;
  assign rd_issue     = (st_q == ST_ISSUE);
  assign ent_from_mem = (st_q == ST_WAIT) && mem_rd_valid;
  assign fill_en      = ent_from_mem && fill_ok_q && !cfg_wr;
  assign resp         = (st_q == ST_RESP);

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 4,
  parameter int OFF_W = 12,
  parameter int PA_W  = 16,
  parameter int TA_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_base_we,
  input  logic [TA_W-1:0]        cfg_base_wdata,
  input  logic                   cfg_len_we,
  input  logic [SEG_W:0]         cfg_len_wdata,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [SEG_W-1:0]       req_seg,
  input  logic [OFF_W-1:0]       req_off,
  input  logic [1:0]             req_acc,
  output logic                   rsp_valid,
  output logic [2:0]             rsp_fault,
  output logic [PA_W-1:0]        rsp_pa,
  output logic                   mem_rd_req,
  output logic [TA_W-1:0]        mem_rd_addr,
  input  logic                   mem_rd_valid,
  input  logic [PA_W+OFF_W+4:0]  mem_rd_data
);

  localparam int LIM_W = OFF_W + 1;
  localparam int EW    = PA_W + LIM_W + 4;

  logic [TA_W-1:0]  tbl_base_q;
  logic [SEG_W:0]   tbl_len_q;
  logic [SEG_W-1:0] seg_q;
  logic [OFF_W-1:0] off_q;
  logic [1:0]       acc_q;
  logic             in_range_q;
  logic [EW-1:0]    ent_q;

  logic             cfg_wr;
  logic             req_in_range;
  logic             cache_hit;
  logic             cache_vld;
  logic [EW-1:0]    cache_entry;
  logic             fast_path;
  logic             accept;
  logic             ent_from_mem;
  logic             fill_en;
  logic [2:0]       chk_fault;
  logic [PA_W-1:0]  chk_pa;
  logic             ent_ok, lim_ok, perm_ok;

  assign cfg_wr       = cfg_base_we || cfg_len_we;
  assign req_in_range = {1'b0, req_seg} < tbl_len_q;
  assign fast_path    = !req_in_range || cache_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_base_q <= '0;
      tbl_len_q  <= '0;
    end else begin
      if (cfg_base_we) tbl_base_q <= cfg_base_wdata;
      if (cfg_len_we)  tbl_len_q  <= cfg_len_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q      <= '0;
      off_q      <= '0;
      acc_q      <= '0;
      in_range_q <= 1'b0;
      ent_q      <= '0;
    end else begin
      if (accept) begin
        seg_q      <= req_seg;
        off_q      <= req_off;
        acc_q      <= req_acc;
        in_range_q <= req_in_range;
        if (cache_hit) ent_q <= cache_entry;
      end
      if (ent_from_mem) ent_q <= mem_rd_data;
    end
  end

  seg_xlate_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .fast         (fast_path),
    .mem_rd_valid (mem_rd_valid),
    .cfg_wr       (cfg_wr),
    .req_ready    (req_ready),
    .accept       (accept),
    .rd_issue     (mem_rd_req),
    .ent_from_mem (ent_from_mem),
    .fill_en      (fill_en),
    .resp         (rsp_valid)
  );

  seg_xlate_cache #(.SEG_W(SEG_W), .EW(EW)) u_cache (
    .clk        (clk),
    .rst_n      (rst_n),
    .inval      (cfg_wr),
    .fill       (fill_en),
    .fill_seg   (seg_q),
    .fill_entry (mem_rd_data),
    .look_seg   (req_seg),
    .hit        (cache_hit),
    .hit_entry  (cache_entry),
    .vld        (cache_vld)
  );

  seg_xlate_check #(.OFF_W(OFF_W), .PA_W(PA_W), .LIM_W(LIM_W), .EW(EW)) u_check (
    .in_range (in_range_q),
    .entry    (ent_q),
    .off      (off_q),
    .acc      (acc_q),
    .fault    (chk_fault),
    .pa       (chk_pa),
    .ent_ok   (ent_ok),
    .lim_ok   (lim_ok),
    .perm_ok  (perm_ok)
  );

  assign mem_rd_addr = tbl_base_q + TA_W'(seg_q);
  assign rsp_fault   = rsp_valid ? chk_fault : FLT_NONE;
  assign rsp_pa      = (rsp_valid && chk_fault == FLT_NONE) ? chk_pa : '0;

endmodule

// File: rtl/seg_xlate_sva.sv
module seg_xlate_sva #(
  parameter int PA_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rsp_valid,
  input logic [2:0]      rsp_fault,
  input logic [PA_W-1:0] rsp_pa,
  input logic            req_ready,
  input logic            mem_rd_req,
  input logic            cfg_wr,
  input logic            cache_vld,
  input logic            accept,
  input logic            fast_path
);

  // R13
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R13
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R2
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |=> !mem_rd_req);

  // R10
  fault_no_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 3'd0) |-> (rsp_pa == '0));

  // R12
  cfg_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !cache_vld);

  // R4
  fast_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && fast_path) |=> (rsp_valid && !mem_rd_req));

  // R8
  fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault <= 3'd4));

endmodule

bind seg_xlate_unit seg_xlate_sva #(.PA_W(PA_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .rsp_valid  (rsp_valid),
  .rsp_fault  (rsp_fault),
  .rsp_pa     (rsp_pa),
  .req_ready  (req_ready),
  .mem_rd_req (mem_rd_req),
  .cfg_wr     (cfg_wr),
  .cache_vld  (cache_vld),
  .accept     (accept),
  .fast_path  (fast_path)
);

// File: tb/seg_xlate_unit_tb_top.sv
module seg_xlate_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_base_we = 1'b0;
  logic [15:0] cfg_base_wdata = '0;
  logic        cfg_len_we = 1'b0;
  logic [4:0]  cfg_len_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_seg = '0;
  logic [11:0] req_off = '0;
  logic [1:0]  req_acc = '0;
  logic        rsp_valid;
  logic [2:0]  rsp_fault;
  logic [15:0] rsp_pa;
  logic        mem_rd_req;
  logic [15:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [32:0] mem_rd_data = '0;

  always #4 clk = ~clk;

  seg_xlate_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_base_we(cfg_base_we), .cfg_base_wdata(cfg_base_wdata),
    .cfg_len_we(cfg_len_we), .cfg_len_wdata(cfg_len_wdata),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_seg(req_seg), .req_off(req_off), .req_acc(req_acc),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  // Memory model: answers a table read three cycles after the request.
  logic [32:0] tbl_mem [0:255];
  int          rd_cnt = 0;
  logic [15:0] last_rd_addr = '0;
  logic [15:0] pend_addr = '0;
  bit          pend = 0;
  int          lat = 0;

  always @(posedge clk) begin
    mem_rd_valid <= 1'b0;
    if (mem_rd_req) begin
      pend         <= 1;
      lat          <= 2;
      pend_addr    <= mem_rd_addr;
      last_rd_addr <= mem_rd_addr;
      rd_cnt       <= rd_cnt + 1;
    end else if (pend) begin
      if (lat == 0) begin
        mem_rd_valid <= 1'b1;
        mem_rd_data  <= tbl_mem[pend_addr[7:0]];
        pend         <= 0;
      end else begin
        lat <= lat - 1;
      end
    end
  end

  // Reference state of the bench.
  int m_base = 0;
  int m_len = 0;
  bit m_cvld = 0;
  int m_cseg = 0;
  logic [32:0] m_cent = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [32:0] mk(input bit v, input bit r, input bit w,
                                     input bit x, input int lim, input int base);
    logic [32:0] e;
    e[15:0]  = base[15:0];
    e[28:16] = lim[12:0];
    e[29]    = x;
    e[30]    = w;
    e[31]    = r;
    e[32]    = v;
    return e;
  endfunction

  task automatic cfg(input bit wb, input int b, input bit wl, input int l);
    @(negedge clk);
    cfg_base_we = wb; cfg_base_wdata = b[15:0];
    cfg_len_we  = wl; cfg_len_wdata  = l[4:0];
    @(negedge clk);
    cfg_base_we = 0; cfg_len_we = 0;
    if (wb) m_base = b;
    if (wl) m_len = l;
    m_cvld = 0;
  endtask

  task automatic xl(input int seg, input int off, input int acc, input string req);
    logic [32:0] e;
    int exp_f, exp_pa, lim, n, rd0;
    bit hit, acc_ok;
    hit = 0;
    if (seg >= m_len) begin
      exp_f = 1;
    end else begin
      hit = m_cvld && (m_cseg == seg);
      e = hit ? m_cent : tbl_mem[(m_base + seg) % 256];
      lim = int'(e[28:16]);
      acc_ok = (acc == 0) ? e[31] : (acc == 1) ? e[30] : (acc == 2) ? e[29] : 1'b0;
      if (!e[32])        exp_f = 2;
      else if (off >= lim) exp_f = 3;
      else if (!acc_ok)  exp_f = 4;
      else               exp_f = 0;
      m_cvld = 1; m_cseg = seg; m_cent = e;
    end
    exp_pa = (exp_f == 0) ? ((int'(e[15:0]) + off) % 65536) : 0;
    rd0 = rd_cnt;
    @(negedge clk);
    req_valid = 1; req_seg = seg[3:0]; req_off = off[11:0]; req_acc = acc[1:0];
    @(negedge clk);
    req_valid = 0;
    n = 1;
    if (!rsp_valid) check(req_ready == 0, "R13", "ready while busy", req_ready, 0);
    while (!rsp_valid && n < 40) begin
      @(negedge clk);
      n++;
    end
    check(rsp_valid == 1, req, "response seen", rsp_valid, 1);
    check(int'(rsp_fault) == exp_f, req, "fault", rsp_fault, exp_f);
    check(int'(rsp_pa) == exp_pa, req, "pa", rsp_pa, exp_pa);
    if (exp_f != 0) check(rsp_pa == 0, "R10", "pa on fault", rsp_pa, 0);
    if (seg >= m_len || hit) begin
      check(n == 1, (seg >= m_len) ? "R4" : "R11", "fast latency", n, 1);
      check(rd_cnt == rd0, (seg >= m_len) ? "R4" : "R11", "no table read", rd_cnt - rd0, 0);
    end else begin
      check(rd_cnt == rd0 + 1, "R2", "one table read", rd_cnt - rd0, 1);
      check(int'(last_rd_addr) == (m_base + seg) % 65536, "R2", "table addr",
            last_rd_addr, (m_base + seg) % 65536);
    end
    @(negedge clk);
    check(rsp_valid == 0, "R13", "single-cycle response", rsp_valid, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) tbl_mem[i] = '0;
    // R3: table words built with the stated field layout
    tbl_mem[16] = mk(1, 1, 1, 1, 100, 16'h1000);
    tbl_mem[17] = mk(1, 1, 0, 0, 64, 16'h2000);
    tbl_mem[18] = mk(0, 1, 1, 1, 8, 16'h3000);
    tbl_mem[19] = mk(1, 0, 1, 0, 5, 16'h4000);
    tbl_mem[20] = mk(1, 1, 1, 1, 4096, 16'hFFF0);
    tbl_mem[21] = mk(1, 1, 1, 1, 0, 16'h5000);
    tbl_mem[22] = mk(1, 1, 1, 1, 50, 16'h6000);
    tbl_mem[23] = mk(1, 1, 1, 1, 50, 16'h7000);
    repeat (3) @(negedge clk);
    // R1: reset state
    check(req_ready == 1, "R1", "req_ready", req_ready, 1);
    check(rsp_valid == 0, "R1", "rsp_valid", rsp_valid, 0);
    check(mem_rd_req == 0, "R1", "mem_rd_req", mem_rd_req, 0);
    rst_n = 1;
    @(negedge clk);
    // R1: count register is zero, so segment 0 is out of range
    xl(0, 0, 0, "R1");

    cfg(1, 16, 1, 6);
    xl(0, 10, 0, "R9");      // miss, read ok
    xl(0, 99, 2, "R11");     // hit, fetch ok at last byte
    xl(0, 100, 1, "R6");     // offset equal to limit
    xl(1, 3, 1, "R7");       // write to read-only
    xl(1, 3, 2, "R7");       // fetch from read-only
    xl(1, 63, 0, "R9");
    xl(2, 0, 0, "R5");
    xl(2, 200, 1, "R8");     // invalid wins over limit
    xl(3, 9, 0, "R8");       // limit wins over denied
    xl(3, 4, 0, "R7");
    xl(3, 4, 1, "R9");
    xl(4, 32, 0, "R9");      // wraps modulo 2^16
    xl(5, 0, 0, "R6");       // zero limit
    xl(6, 0, 0, "R4");       // equal to count
    xl(15, 7, 0, "R4");
    xl(0, 1, 0, "R9");
    // R11: stale cached entry is still used
    tbl_mem[16] = mk(1, 1, 1, 1, 100, 16'h8000);
    xl(0, 2, 0, "R11");
    // R12: rewriting the count with the same value drops the cache
    cfg(0, 0, 1, 6);
    xl(0, 2, 0, "R12");
    xl(0, 3, 0, "R11");
    tbl_mem[16] = mk(1, 1, 1, 1, 100, 16'h9000);
    cfg(1, 16, 0, 0);
    xl(0, 3, 0, "R12");
    // R2: moved table base
    tbl_mem[40] = mk(1, 1, 1, 1, 20, 16'h0A00);
    cfg(1, 40, 0, 0);
    xl(0, 5, 1, "R2");
    done = 1;
  end

  initial begin
    while (!done && cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule